// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives a raster display. It counts pixels across each line and lines down each frame. From those counts it derives the active-video window, the horizontal and vertical sync pulses, and a prefetch strobe. The strobe fires at a programmed pixel late in every line, so that memory fetch for the next line can start early. All geometry comes from registers that a host writes through a simple write port. Each limit is stored as the count value at which the event happens, which is one less than the corresponding length.

Sync output is shaped by a separate sync control register. That register sets per-signal polarity inversion and a composite sync-on-RGB flag. It also provides three suppression controls used for power management: all sync off, horizontal sync off and vertical sync off. A display-off flag forces the video-enable output low without disturbing the timing. A scroll origin register supplies a pixel and line offset, and the block adds that offset to the live counts to form the fetch coordinate.

Timing writes made while the generator runs are held in staging storage. They move into the live set only at the end of a frame, so no frame mixes old and new geometry. Pixel-clock generation and the memory fetch itself are outside this block.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every register is zero. Both counts are 0, and active, video_on, hsync, vsync, rgb_sync, prefetch, fetch_x and fetch_y are all 0.
- R2: The control register is at address 0, and its bit 0 is the run enable. While run is clear, both counts hold at 0. While run is set, h_count steps by one each cycle and returns to 0 after reaching the line-total value (address 1). On each return, v_count steps by one, and v_count returns to 0 after the frame-total value (address 5).
- R3: `active` is 1 when run is set, refresh (control bit 1) is set, h_count ≤ horizontal display value (address 2) and v_count ≤ vertical display value (address 6). `video_on` equals `active` except that it is 0 whenever the display-off flag is set (bit 1 of address 11).
- R4: The raw horizontal sync is on while h_count is above the start value (address 3) and no more than the end value (address 4). The raw vertical sync uses v_count with addresses 7 and 8 in the same way. Both raw syncs are 0 while run is clear.
- R5: `prefetch` is 1 exactly when run is set and h_count equals the early-point value (address 9).
- R6: In the sync control register (address 10), bit 3 inverts the hsync pin and bit 4 inverts the vsync pin. An inverted pin idles high.
- R7: In the sync control register, bit 1 suppresses both syncs, bit 5 suppresses horizontal sync only and bit 6 suppresses vertical sync only. A suppressed sync pin stays at its idle level.
- R8: `rgb_sync` is 1 when sync control bit 0 is set and either sync is on after suppression.
- R9: The origin register (address 12) holds X in bits [31:16] and Y in bits [15:0]. A write whose X is not a multiple of 8 is ignored as a whole. fetch_x = X + h_count and fetch_y = Y + v_count.
- R10: A write to addresses 1 to 9 while run is set takes effect on the cycle after the last cycle of the current frame. While run is clear, such a write takes effect one cycle after it is captured.
- R11: Control, sync control, display-off and origin writes take effect on the cycle after they are captured. With run set and refresh clear, the counters still run and `active` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| h_count | output | CNT_W | Pixel count within the line |
| v_count | output | CNT_W | Line count within the frame |
| active | output | 1 | Inside the active window |
| video_on | output | 1 | Active and display not switched off |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| rgb_sync | output | 1 | Composite sync for sync-on-RGB |
| prefetch | output | 1 | Early-line prefetch strobe |
| fetch_x | output | ORG_W | Origin X plus h_count |
| fetch_y | output | ORG_W | Origin Y plus v_count |

## Verification
A write presented before a clock edge is captured at that edge. Control, sync, display and origin values act on the very next cycle. A captured timing value reaches the live set one edge later when stopped, or at the frame wrap when running. The counters are registers, and every other output is a combinational function of the counters and the live registers. So every output is due in the cycle right after the edge that updated its inputs. The bench drives inputs on the falling edge and keeps its own model registers, updated on the rising edge from the requirements. It compares all outputs against that model on every falling edge, and adds targeted checks at the sync borders, at the prefetch point and in the frame where a mid-frame write becomes live.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_HTOT   = 4'd1,
    A_HACT   = 4'd2,
    A_HSS    = 4'd3,
    A_HSE    = 4'd4,
    A_VTOT   = 4'd5,
    A_VACT   = 4'd6,
    A_VSS    = 4'd7,
    A_VSE    = 4'd8,
    A_EARLY  = 4'd9,
    A_SYNC   = 4'd10,
    A_DISP   = 4'd11,
    A_ORIGIN = 4'd12
  } reg_addr_e;

  // timing slots; slot i lives at address i+1
  localparam int NUM_TIMING = 9;
  localparam int T_HTOT  = 0;
  localparam int T_HACT  = 1;
  localparam int T_HSS   = 2;
  localparam int T_HSE   = 3;
  localparam int T_VTOT  = 4;
  localparam int T_VACT  = 5;
  localparam int T_VSS   = 6;
  localparam int T_VSE   = 7;
  localparam int T_EARLY = 8;

  // sync control bit positions
  localparam int SB_RGB   = 0;
  localparam int SB_OFF   = 1;
  localparam int SB_HINV  = 3;
  localparam int SB_VINV  = 4;
  localparam int SB_HOFF  = 5;
  localparam int SB_VOFF  = 6;
  localparam int SYNC_W   = 7;

  // window (start, end]
  function automatic logic in_window(input logic [15:0] cnt,
                                     input logic [15:0] start_v,
                                     input logic [15:0] end_v);
    return (cnt > start_v) && (cnt <= end_v);
  endfunction

  function automatic logic pin_level(input logic on, input logic inv);
    return on ^ inv;
  endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ORG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             frame_end,
  output logic             ctrl_en,
  output logic             ctrl_refresh,
  output logic [CNT_W-1:0] live_t [NUM_TIMING],
  output logic [SYNC_W-1:0] sync_ctl,
  output logic             disp_off,
  output logic [ORG_W-1:0] org_x,
  output logic [ORG_W-1:0] org_y
);

  localparam int XLSB = 16;

  logic [CNT_W-1:0] stage_t [NUM_TIMING];
  wire load_live = !ctrl_en || frame_end;
  wire origin_ok = (wr_data[XLSB+2:XLSB] == 3'd0);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TIMING; gi++) begin : g_slot
      wire hit = wr_en && (wr_addr == 4'(gi + 1));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_t[gi] <= '0;
          live_t[gi]  <= '0;
        end else begin
          if (hit)       stage_t[gi] <= wr_data[CNT_W-1:0];
          if (load_live) live_t[gi]  <= stage_t[gi];
        end
      end

      AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !frame_end) |=> (live_t[gi] == $past(live_t[gi]))); // R10
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en      <= 1'b0;
      ctrl_refresh <= 1'b0;
      sync_ctl     <= '0;
      disp_off     <= 1'b0;
      org_x        <= '0;
      org_y        <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          ctrl_en      <= wr_data[0];
          ctrl_refresh <= wr_data[1];
        end
        A_SYNC:  sync_ctl <= wr_data[SYNC_W-1:0];
        A_DISP:  disp_off <= wr_data[1];
        A_ORIGIN: if (origin_ok) begin
          org_x <= wr_data[XLSB +: ORG_W];
          org_y <= wr_data[ORG_W-1:0];
        end
        default: ;
      endcase
    end
  end

  AST_ORIGIN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    org_x[2:0] == 3'd0); // R9

endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] htot,
  input  logic [CNT_W-1:0] vtot,
  output logic [CNT_W-1:0] h_cnt,
  output logic [CNT_W-1:0] v_cnt,
  output logic             line_end,
  output logic             frame_end
);

  assign line_end  = en && (h_cnt == htot);
  assign frame_end = line_end && (v_cnt == vtot);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (line_end) begin
      h_cnt <= '0;
      v_cnt <= frame_end ? '0 : v_cnt + CNT_W'(1);
    end else begin
      h_cnt <= h_cnt + CNT_W'(1);
    end
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (h_cnt == '0 && v_cnt == '0)); // R2
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> h_cnt == '0); // R2
  AST_V_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !frame_end) |=> v_cnt == $past(v_cnt) + CNT_W'(1)); // R2
  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !line_end) |=> h_cnt == $past(h_cnt) + CNT_W'(1)); // R2

endmodule

// File: rtl/rtg_outputs.sv
module rtg_outputs
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ORG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              refresh,
  input  logic [CNT_W-1:0]  h_cnt,
  input  logic [CNT_W-1:0]  v_cnt,
  input  logic [CNT_W-1:0]  live_t [NUM_TIMING],
  input  logic [SYNC_W-1:0] sync_ctl,
  input  logic              disp_off,
  input  logic [ORG_W-1:0]  org_x,
  input  logic [ORG_W-1:0]  org_y,
  output logic              active,
  output logic              video_on,
  output logic              hsync,
  output logic              vsync,
  output logic              rgb_sync,
  output logic              prefetch,
  output logic [ORG_W-1:0]  fetch_x,
  output logic [ORG_W-1:0]  fetch_y
);

  logic h_raw, v_raw, h_on, v_on;

  always_comb begin
    h_raw = en && in_window(16'(h_cnt), 16'(live_t[T_HSS]), 16'(live_t[T_HSE]));
    v_raw = en && in_window(16'(v_cnt), 16'(live_t[T_VSS]), 16'(live_t[T_VSE]));
    h_on  = h_raw && !sync_ctl[SB_OFF] && !sync_ctl[SB_HOFF];
    v_on  = v_raw && !sync_ctl[SB_OFF] && !sync_ctl[SB_VOFF];
    hsync    = pin_level(h_on, sync_ctl[SB_HINV]);
    vsync    = pin_level(v_on, sync_ctl[SB_VINV]);
    rgb_sync = sync_ctl[SB_RGB] && (h_on || v_on);
    active   = en && refresh && (h_cnt <= live_t[T_HACT]) && (v_cnt <= live_t[T_VACT]);
    video_on = active && !disp_off;
    prefetch = en && (h_cnt == live_t[T_EARLY]);
    fetch_x  = org_x + ORG_W'(h_cnt);
    fetch_y  = org_y + ORG_W'(v_cnt);
  end

  AST_VIDEO_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    video_on |-> active); // R3
  AST_SYNC_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ctl[SB_OFF] |-> (hsync == sync_ctl[SB_HINV] && vsync == sync_ctl[SB_VINV])); // R7
  AST_PREFETCH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch |-> en); // R5
  AST_RGB_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_sync |-> sync_ctl[SB_RGB]); // R8

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int ORG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic [CNT_W-1:0] h_count,
  output logic [CNT_W-1:0] v_count,
  output logic             active,
  output logic             video_on,
  output logic             hsync,
  output logic             vsync,
  output logic             rgb_sync,
  output logic             prefetch,
  output logic [ORG_W-1:0] fetch_x,
  output logic [ORG_W-1:0] fetch_y
);

  logic              ctrl_en, ctrl_refresh, disp_off;
  logic [CNT_W-1:0]  live_t [NUM_TIMING];
  logic [SYNC_W-1:0] sync_ctl;
  logic [ORG_W-1:0]  org_x, org_y;
  logic              line_end, frame_end;

  rtg_regs #(.CNT_W(CNT_W), .ORG_W(ORG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_end(frame_end), .ctrl_en(ctrl_en), .ctrl_refresh(ctrl_refresh),
    .live_t(live_t), .sync_ctl(sync_ctl), .disp_off(disp_off),
    .org_x(org_x), .org_y(org_y)
  );

  rtg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en),
    .htot(live_t[T_HTOT]), .vtot(live_t[T_VTOT]),
    .h_cnt(h_count), .v_cnt(v_count), .line_end(line_end), .frame_end(frame_end)
  );

  rtg_outputs #(.CNT_W(CNT_W), .ORG_W(ORG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .refresh(ctrl_refresh),
    .h_cnt(h_count), .v_cnt(v_count), .live_t(live_t), .sync_ctl(sync_ctl),
    .disp_off(disp_off), .org_x(org_x), .org_y(org_y),
    .active(active), .video_on(video_on), .hsync(hsync), .vsync(vsync),
    .rgb_sync(rgb_sync), .prefetch(prefetch), .fetch_x(fetch_x), .fetch_y(fetch_y)
  );

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (h_count == '0 && v_count == '0)); // R2

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int OW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [CW-1:0] h_count, v_count;
  logic active, video_on, hsync, vsync, rgb_sync, prefetch;
  logic [OW-1:0] fetch_x, fetch_y;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen #(.CNT_W(CW), .ORG_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .h_count(h_count), .v_count(v_count), .active(active), .video_on(video_on),
    .hsync(hsync), .vsync(vsync), .rgb_sync(rgb_sync), .prefetch(prefetch),
    .fetch_x(fetch_x), .fetch_y(fetch_y)
  );

  int nchk = 0;
  int nerr = 0;
  bit mon = 1'b0;
  bit done = 1'b0;

  // bench model; slot i = address i+1
  logic [1:0]    m_ctrl;
  logic [CW-1:0] m_stg [9];
  logic [CW-1:0] m_live [9];
  logic [6:0]    m_sync;
  logic          m_disp;
  logic [OW-1:0] m_ox, m_oy;
  logic [CW-1:0] m_h, m_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_sync <= '0; m_disp <= 1'b0; m_ox <= '0; m_oy <= '0;
      m_h <= '0; m_v <= '0;
      for (int i = 0; i < 9; i++) begin m_stg[i] <= '0; m_live[i] <= '0; end
    end else begin
      if (!m_ctrl[0]) begin
        m_h <= '0; m_v <= '0;
      end else if (m_h == m_live[0]) begin
        m_h <= '0;
        m_v <= (m_v == m_live[4]) ? '0 : m_v + 1'b1;
      end else m_h <= m_h + 1'b1;
      if (!m_ctrl[0] || (m_h == m_live[0] && m_v == m_live[4]))
        for (int i = 0; i < 9; i++) m_live[i] <= m_stg[i];
      if (wr_en) begin
        if (wr_addr == 4'd0) m_ctrl <= wr_data[1:0];
        else if (wr_addr <= 4'd9) m_stg[wr_addr - 4'd1] <= wr_data[CW-1:0];
        else if (wr_addr == 4'd10) m_sync <= wr_data[6:0];
        else if (wr_addr == 4'd11) m_disp <= wr_data[1];
        else if (wr_addr == 4'd12 && wr_data[18:16] == 3'd0) begin
          m_ox <= wr_data[31:16]; m_oy <= wr_data[15:0];
        end
      end
    end
  end

  function automatic logic e_active();
    return m_ctrl[0] && m_ctrl[1] && (m_h <= m_live[1]) && (m_v <= m_live[5]);
  endfunction
  function automatic logic e_hon();
    return m_ctrl[0] && (m_h > m_live[2]) && (m_h <= m_live[3]) && !m_sync[1] && !m_sync[5];
  endfunction
  function automatic logic e_von();
    return m_ctrl[0] && (m_v > m_live[6]) && (m_v <= m_live[7]) && !m_sync[1] && !m_sync[6];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h (h=%0d v=%0d)", tag, got, exp, m_h, m_v);
    end
  endtask

  always @(negedge clk) begin
    if (mon && !done) begin
      chk("R2 h_count", 32'(h_count), 32'(m_h));
      chk("R2 v_count", 32'(v_count), 32'(m_v));
      chk("R3 active", 32'(active), 32'(e_active()));
      chk("R3 video_on", 32'(video_on), 32'(e_active() && !m_disp));
      chk("R4 hsync", 32'(hsync), 32'(e_hon() ^ m_sync[3]));
      chk("R4 vsync", 32'(vsync), 32'(e_von() ^ m_sync[4]));
      chk("R5 prefetch", 32'(prefetch), 32'(m_ctrl[0] && m_h == m_live[8]));
      chk("R8 rgb_sync", 32'(rgb_sync), 32'(m_sync[0] && (e_hon() || e_von())));
      chk("R9 fetch_x", 32'(fetch_x), 32'(m_ox + OW'(m_h)));
      chk("R9 fetch_y", 32'(fetch_y), 32'(m_oy + OW'(m_v)));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_at(input int hh, input int vv);
    forever begin
      @(negedge clk);
      if (m_h == CW'(hh) && (vv < 0 || m_v == CW'(vv))) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 h", 32'(h_count), 0); chk("R1 v", 32'(v_count), 0);
    chk("R1 active", 32'(active), 0); chk("R1 video_on", 32'(video_on), 0);
    chk("R1 hsync", 32'(hsync), 0); chk("R1 vsync", 32'(vsync), 0);
    chk("R1 rgb_sync", 32'(rgb_sync), 0); chk("R1 prefetch", 32'(prefetch), 0);
    chk("R1 fetch", 32'({fetch_x, fetch_y}), 0);

    // timing: 20 pixels x 10 lines
    wr(4'd1, 19); wr(4'd2, 11); wr(4'd3, 13); wr(4'd4, 15);
    wr(4'd5, 9);  wr(4'd6, 5);  wr(4'd7, 6);  wr(4'd8, 7); wr(4'd9, 17);
    mon = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 hold while stopped", 32'(h_count), 0);
    wr(4'd0, 3);
    repeat (220) @(negedge clk);

    // R4 window borders, R5 early point
    wait_at(13, 0); chk("R4 hsync before start", 32'(hsync), 0);
    wait_at(15, -1); chk("R4 hsync at end", 32'(hsync), 1);
    wait_at(17, -1); chk("R5 prefetch at early point", 32'(prefetch), 1);

    // R11 refresh clear: counters run, active low
    wr(4'd0, 1);
    wait_at(2, -1); chk("R11 active with refresh off", 32'(active), 0);
    repeat (30) @(negedge clk);
    wr(4'd0, 3);
    repeat (30) @(negedge clk);

    // R6 inversion
    wr(4'd10, 32'h18);
    wait_at(0, 2); chk("R6 hsync idle high", 32'(hsync), 1);
    chk("R6 vsync idle high", 32'(vsync), 1);
    repeat (200) @(negedge clk);
    // R7 suppression variants
    wr(4'd10, 32'h20);
    wait_at(14, -1); chk("R7 hsync suppressed", 32'(hsync), 0);
    repeat (200) @(negedge clk);
    wr(4'd10, 32'h40);
    wait_at(3, 7); chk("R7 vsync suppressed", 32'(vsync), 0);
    repeat (200) @(negedge clk);
    wr(4'd10, 32'h1A);
    wait_at(14, -1); chk("R7 all off inverted idle", 32'(hsync), 1);
    repeat (200) @(negedge clk);
    // R8 sync on RGB
    wr(4'd10, 32'h01);
    wait_at(14, 1); chk("R8 rgb_sync in hsync", 32'(rgb_sync), 1);
    repeat (200) @(negedge clk);
    wr(4'd10, 32'h19);
    repeat (200) @(negedge clk);

    // R3 display off
    wr(4'd11, 2);
    wait_at(0, 0); chk("R3 video_on off", 32'(video_on), 0);
    chk("R3 active kept", 32'(active), 1);
    repeat (200) @(negedge clk);
    wr(4'd11, 0);

    // R9 origin accept and reject
    wr(4'd12, {16'd16, 16'd3});
    wait_at(0, 0); chk("R9 fetch_x origin", 32'(fetch_x), 16);
    chk("R9 fetch_y origin", 32'(fetch_y), 3);
    wr(4'd12, {16'd13, 16'd9});
    wait_at(2, 1); chk("R9 misaligned ignored x", 32'(fetch_x), 18);
    chk("R9 misaligned ignored y", 32'(fetch_y), 4);
    repeat (50) @(negedge clk);

    // R10 mid-frame timing write
    wait_at(5, 2);
    wr(4'd2, 4);
    chk("R10 old width still live", 32'(active), 1);
    wait_at(7, 0); chk("R10 new width next frame", 32'(active), 0);
    wait_at(4, 1); chk("R10 new width edge", 32'(active), 1);
    repeat (250) @(negedge clk);

    mon = 1'b0;
    finish_run();
  end
endmodule